// File: doc/BRIEF.md
# Floating-Point Exception Instruction Capture Register

When the floating-point unit bounces a data-processing instruction to support software, this block holds a copy of that instruction. The copy goes into a primary register. A later issued instruction can be copied into an optional secondary register. Both copies are sealed on the way in: the top byte is forced to the always-condition coprocessor data-processing opcode, and bit 4 is forced to zero.

For short-vector operations, the primary copy does not keep the issued register numbers. Each vector register field is rewritten to point at the register used by the iteration that raised the exception. The block also stores how many iterations still have to be done.

Two valid flags, one per register, say which register holds meaningful content. Support software uses a small read/write port to inspect and patch both registers, read the remaining-iteration count, and clear the flags. The block does not decide that an exception happened: a capture strobe, the vector length, the stride and the faulting iteration index all arrive as inputs.

Top module: `fpx_capture`

## Requirements
- R1: A capture seals the stored word: bits [31:24] become 8'hEE and bit 4 becomes 0. The field positions are D at bit 22, Vn at [19:16], Vd at [15:12], coprocessor number at [11:8], N at bit 7, Q at bit 6, M at bit 5 and Vm at [3:0]. All bits that are neither reserved nor rewritten are stored unchanged.
- R2: A software write to address 0 (primary) or address 1 (secondary) cannot change bits [31:24] or bit 4. A read of either address always returns 8'hEE in bits [31:24] and 0 in bit 4.
- R3: The primary register rewrites three 5-bit register numbers: destination {Vd,D}, first source {Vn,N} and second source {Vm,M}. When vec_len is non-zero and a number's bank bits [4:3] are non-zero, its low 3 bits become (low + vec_iter × stride) mod 8. The stride is 2 when vec_stride2 is 1 and 1 otherwise. Bits [4:3] are kept.
- R4: A register number in bank 0 is stored unchanged. All register numbers are stored unchanged when vec_len is 0.
- R5: A primary capture stores the remaining count vec_len + 1 − vec_iter. Software reads it at bits [11:8] of address 2.
- R6: A primary capture sets the exception-valid flag, which reads at bit 0 of address 2.
- R7: A secondary capture sets the second-valid flag, which reads at bit 1 of address 2. The secondary register is sealed but never has its register fields rewritten.
- R8: A software write to address 2 clears the exception-valid flag when wdata bit 0 is 0, and clears the second-valid flag when wdata bit 1 is 0. A 1 in either bit leaves that flag as it was.
- R9: A capture wins over a software write in the same cycle, both for its register contents and for its flag.
- R10: A synchronous active-high reset clears both flags and the remaining count, so address 2 reads 0. Address 3 always reads 0, and writes to it are ignored.
- R11: A capture or software write takes effect on the first rising edge that samples its strobe. Reads are combinational from the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_valid | input | 1 | Capture the bounced instruction into the primary register |
| cap_word | input | 32 | Bounced instruction as issued |
| vec_len | input | 3 | Vector length minus one (0 = scalar) |
| vec_stride2 | input | 1 | Vector stride is 2 when set, 1 otherwise |
| vec_iter | input | 3 | Index of the iteration that raised the exception |
| cap2_valid | input | 1 | Capture the second issued instruction into the secondary register |
| cap2_word | input | 32 | Second issued instruction |
| sw_wr | input | 1 | Software write strobe |
| sw_addr | input | 2 | 0 primary, 1 secondary, 2 flags/count, 3 unused |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Software read data for sw_addr |

## Verification
The hardest situation to reach is a vector capture in which all three register fields are rewritten and the offset wraps past the end of an 8-register bank. Reaching it takes a non-zero length, a late iteration, stride 2, and every field outside bank 0, all at once. Directed steps build that case and its scalar and bank-0 counterparts. A long random phase then draws lengths, iteration indices no larger than the length, strides, and full words, so fields land in every bank. Same-cycle collisions between captures and software writes to the same address are forced in directed steps and also arise in the random phase.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int WORD_W   = 32;
    localparam int REGNUM_W = 5;
    localparam int BANK_W   = 3;
    localparam int LEN_W    = 3;
    localparam int CNT_W    = LEN_W + 1;
    localparam int NFIELDS  = 3;

    localparam logic [7:0] SEAL_TOP = 8'hEE;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ADR_PRIM  = 2'd0,
        ADR_SEC   = 2'd1,
        ADR_FLAGS = 2'd2,
        ADR_NONE  = 2'd3
    } adr_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             stride2;
        logic [LEN_W-1:0] iter;
    } vcfg_t;

    // Bit position of the 4-bit upper part of each register-number field.
    function automatic int fld_hi_lsb(input int k);
        case (k)
            0:       return 12;
            1:       return 16;
            default: return 0;
        endcase
    endfunction

    // Bit position of the single low bit of each register-number field.
    function automatic int fld_lo_bit(input int k);
        case (k)
            0:       return 22;
            1:       return 7;
            default: return 5;
        endcase
    endfunction

    function automatic word_t seal(input word_t w);
        return {SEAL_TOP, w[23:5], 1'b0, w[3:0]};
    endfunction

    // Advance a register number to the faulting iteration, wrapping inside its bank.
    function automatic logic [REGNUM_W-1:0] step_reg(input logic [REGNUM_W-1:0] num,
                                                     input vcfg_t cfg);
        logic [LEN_W:0]        offs;
        logic [BANK_W-1:0]     low;
        if (cfg.len == '0 || num[REGNUM_W-1:BANK_W] == '0)
            return num;
        offs = cfg.stride2 ? {cfg.iter, 1'b0} : {1'b0, cfg.iter};
        low  = num[BANK_W-1:0] + offs[BANK_W-1:0];
        return {num[REGNUM_W-1:BANK_W], low};
    endfunction

endpackage

// File: rtl/fpx_vec_remap.sv
module fpx_vec_remap
    import fpx_pkg::*;
(
    input  word_t in_word,
    input  vcfg_t cfg,
    output word_t out_word
);
    logic [REGNUM_W-1:0] num_new [NFIELDS];

    for (genvar k = 0; k < NFIELDS; k++) begin : g_fld
        localparam int HI = fld_hi_lsb(k);
        localparam int LO = fld_lo_bit(k);
        logic [REGNUM_W-1:0] num_in;
        assign num_in     = {in_word[HI +: 4], in_word[LO]};
        assign num_new[k] = step_reg(num_in, cfg);
    end

    always_comb begin
        out_word = in_word;
        for (int k = 0; k < NFIELDS; k++) begin
            out_word[fld_hi_lsb(k) +: 4] = num_new[k][REGNUM_W-1:1];
            out_word[fld_lo_bit(k)]      = num_new[k][0];
        end
    end
endmodule

// File: rtl/fpx_word_reg.sv
module fpx_word_reg
    import fpx_pkg::*;
#(
    parameter bit REMAP = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  cap,
    input  word_t cap_word,
    input  vcfg_t cfg,
    input  logic  wr,
    input  word_t wdata,
    output word_t q
);
    word_t shaped;

    if (REMAP) begin : g_remap
        fpx_vec_remap i_remap (.in_word(cap_word), .cfg(cfg), .out_word(shaped));
    end else begin : g_plain
        assign shaped = cap_word;
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= seal('0);
        else if (cap)
            q <= seal(shaped);
        else if (wr)
            q <= seal(wdata);
    end

    AST_CAP_LATCH: assert property (@(posedge clk) disable iff (rst)
        cap |=> q[23:5] == $past(shaped[23:5]) && q[3:0] == $past(shaped[3:0])); // R11
    AST_SW_STORE: assert property (@(posedge clk) disable iff (rst)
        (wr && !cap) |=> q[23:5] == $past(wdata[23:5]) && q[3:0] == $past(wdata[3:0])); // R9
    if (!REMAP) begin : g_chk_plain
        AST_NO_REWRITE: assert property (@(posedge clk) disable iff (rst)
            cap |=> q[23:0] == {$past(cap_word[23:5]), 1'b0, $past(cap_word[3:0])}); // R7
    end
endmodule

// File: rtl/fpx_flags.sv
module fpx_flags
    import fpx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cap,
    input  logic             cap2,
    input  vcfg_t            cfg,
    input  logic             wr,
    input  logic [1:0]       keep,
    output logic             ex,
    output logic             fp2v,
    output logic [CNT_W-1:0] remain
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ex     <= 1'b0;
            fp2v   <= 1'b0;
            remain <= '0;
        end else begin
            if (cap)
                ex <= 1'b1;
            else if (wr)
                ex <= ex & keep[0];
            if (cap2)
                fp2v <= 1'b1;
            else if (wr)
                fp2v <= fp2v & keep[1];
            if (cap)
                remain <= CNT_W'(cfg.len) + CNT_W'(1) - CNT_W'(cfg.iter);
        end
    end

    AST_EX_SET: assert property (@(posedge clk) disable iff (rst) cap |=> ex); // R6
    AST_FP2V_SET: assert property (@(posedge clk) disable iff (rst) cap2 |=> fp2v); // R7
    AST_EX_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr && !keep[0] && !cap) |=> !ex); // R8
    AST_EX_KEEP: assert property (@(posedge clk) disable iff (rst)
        (!cap && !(wr && !keep[0])) |=> ex == $past(ex)); // R8
    AST_REMAIN: assert property (@(posedge clk) disable iff (rst)
        cap |=> remain == CNT_W'($past(cfg.len)) + CNT_W'(1) - CNT_W'($past(cfg.iter))); // R5
    AST_REMAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(remain)); // R5
endmodule

// File: rtl/fpx_capture.sv
module fpx_capture
    import fpx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cap_valid,
    input  logic [31:0] cap_word,
    input  logic [2:0]  vec_len,
    input  logic        vec_stride2,
    input  logic [2:0]  vec_iter,
    input  logic        cap2_valid,
    input  logic [31:0] cap2_word,
    input  logic        sw_wr,
    input  logic [1:0]  sw_addr,
    input  logic [31:0] sw_wdata,
    output logic [31:0] sw_rdata
);
    vcfg_t            cfg;
    word_t            prim_q, sec_q;
    logic             ex, fp2v;
    logic [CNT_W-1:0] remain;
    adr_e             adr;

    assign cfg = '{len: vec_len, stride2: vec_stride2, iter: vec_iter};
    assign adr = adr_e'(sw_addr);

    fpx_word_reg #(.REMAP(1'b1)) i_prim (
        .clk(clk), .rst(rst), .cap(cap_valid), .cap_word(cap_word), .cfg(cfg),
        .wr(sw_wr && adr == ADR_PRIM), .wdata(sw_wdata), .q(prim_q)
    );

    fpx_word_reg #(.REMAP(1'b0)) i_sec (
        .clk(clk), .rst(rst), .cap(cap2_valid), .cap_word(cap2_word), .cfg(cfg),
        .wr(sw_wr && adr == ADR_SEC), .wdata(sw_wdata), .q(sec_q)
    );

    fpx_flags i_flags (
        .clk(clk), .rst(rst), .cap(cap_valid), .cap2(cap2_valid), .cfg(cfg),
        .wr(sw_wr && adr == ADR_FLAGS), .keep(sw_wdata[1:0]),
        .ex(ex), .fp2v(fp2v), .remain(remain)
    );

    always_comb begin
        case (adr)
            ADR_PRIM:  sw_rdata = prim_q;
            ADR_SEC:   sw_rdata = sec_q;
            ADR_FLAGS: sw_rdata = {{(WORD_W-12){1'b0}}, remain, 6'b0, fp2v, ex};
            default:   sw_rdata = '0;
        endcase
    end

    AST_SEALED_READ: assert property (@(posedge clk) disable iff (rst)
        (sw_addr == 2'd0 || sw_addr == 2'd1) |-> sw_rdata[31:24] == 8'hEE && !sw_rdata[4]); // R2
    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sw_addr == 2'd3) |-> sw_rdata == '0); // R10
    AST_CAP_WINS: assert property (@(posedge clk) disable iff (rst)
        (cap_valid && sw_wr && sw_addr == 2'd2 && !sw_wdata[0]) |=> ex); // R9
endmodule

// File: tb/test_fpx_capture.sv
module test_fpx_capture;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cap_valid = 1'b0;
    logic [31:0] cap_word = '0;
    logic [2:0]  vec_len = '0;
    logic        vec_stride2 = 1'b0;
    logic [2:0]  vec_iter = '0;
    logic        cap2_valid = 1'b0;
    logic [31:0] cap2_word = '0;
    logic        sw_wr = 1'b0;
    logic [1:0]  sw_addr = '0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    string tag = "R10";

    // behavioural model state
    logic [31:0] m_prim, m_sec;
    int          m_ex, m_fp2v, m_rem;

    always #5 clk = ~clk;

    fpx_capture i_fpx_capture (.*);

    function automatic logic [31:0] m_seal(input logic [31:0] w);
        logic [31:0] r = w;
        r[31:24] = 8'hEE;
        r[4]     = 1'b0;
        return r;
    endfunction

    function automatic int m_step(input int num, input int len, input int iter, input int st);
        if (len == 0 || num / 8 == 0) return num;
        return (num / 8) * 8 + ((num % 8) + iter * st) % 8;
    endfunction

    function automatic logic [31:0] m_vec(input logic [31:0] w, input int len, input int iter,
                                          input int st);
        logic [31:0] r = w;
        int d, n, m;
        d = m_step(int'(w[15:12]) * 2 + int'(w[22]), len, iter, st);
        n = m_step(int'(w[19:16]) * 2 + int'(w[7]), len, iter, st);
        m = m_step(int'(w[3:0]) * 2 + int'(w[5]), len, iter, st);
        r[15:12] = 4'(d / 2); r[22] = 1'(d % 2);
        r[19:16] = 4'(n / 2); r[7]  = 1'(n % 2);
        r[3:0]   = 4'(m / 2); r[5]  = 1'(m % 2);
        return r;
    endfunction

    task automatic model_edge();
        int st = vec_stride2 ? 2 : 1;
        if (rst) begin
            m_ex = 0; m_fp2v = 0; m_rem = 0;
            return;
        end
        if (cap_valid)
            m_prim = m_seal(m_vec(cap_word, int'(vec_len), int'(vec_iter), st));
        else if (sw_wr && sw_addr == 2'd0)
            m_prim = m_seal(sw_wdata);
        if (cap2_valid)
            m_sec = m_seal(cap2_word);
        else if (sw_wr && sw_addr == 2'd1)
            m_sec = m_seal(sw_wdata);
        if (cap_valid) begin
            m_ex  = 1;
            m_rem = int'(vec_len) + 1 - int'(vec_iter);
        end else if (sw_wr && sw_addr == 2'd2) begin
            m_ex = m_ex & int'(sw_wdata[0]);
        end
        if (cap2_valid)
            m_fp2v = 1;
        else if (sw_wr && sw_addr == 2'd2)
            m_fp2v = m_fp2v & int'(sw_wdata[1]);
    endtask

    task automatic compare();
        logic [31:0] exp;
        bit          skip = 0;
        case (sw_addr)
            2'd0: begin exp = m_prim; skip = (m_ex == 0); end
            2'd1: begin exp = m_sec; skip = (m_ex == 0 || m_fp2v == 0); end
            2'd2: exp = 32'(m_rem) << 8 | 32'(m_fp2v) << 1 | 32'(m_ex);
            default: exp = '0;
        endcase
        if (skip) return;
        n_cmp++;
        if (sw_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, sw_addr, sw_rdata, exp);
        end
    endtask

    // one clock step: inputs already driven; model the edge, then compare
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
        cap_valid = 0; cap2_valid = 0; sw_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a);
        sw_addr = a;
        step();
    endtask

    task automatic capt(input logic [31:0] w, input int len, input int iter, input bit s2);
        cap_valid = 1; cap_word = w; vec_len = 3'(len); vec_iter = 3'(iter); vec_stride2 = s2;
    endtask

    initial begin : watchdog
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        m_prim = '0; m_sec = '0; m_ex = 0; m_fp2v = 0; m_rem = 0;
        @(negedge clk);
        rst = 1; step(); step();
        rst = 0;
        tag = "R10"; rd(2'd2); rd(2'd3);

        // scalar capture: fields unchanged, reserved sealed
        tag = "R4"; capt(32'h12F3_A5FF, 0, 0, 1); sw_addr = 2'd0; step();
        tag = "R1"; rd(2'd0);
        tag = "R6"; rd(2'd2);

        // all fields in high banks, wrap with stride 2
        tag = "R3"; capt({8'h00, 1'b0, 1'b1, 2'b00, 4'hB, 4'h9, 4'h5, 1'b1, 1'b0, 1'b1, 1'b1, 4'hE},
                         7, 5, 1);
        step(); rd(2'd0);
        tag = "R5"; rd(2'd2);
        tag = "R3"; capt(32'h00D7_6BA3, 3, 2, 0); step(); rd(2'd0);

        // destination in bank 0 stays
        tag = "R4"; capt({8'h00, 1'b0, 1'b0, 2'b00, 4'hC, 4'h2, 4'h5, 1'b0, 1'b0, 1'b0, 1'b0, 4'h3},
                         5, 3, 1);
        step(); rd(2'd0);

        // software write cannot touch reserved bits
        tag = "R2"; sw_wr = 1; sw_addr = 2'd0; sw_wdata = 32'hFFFF_FFFF; step(); rd(2'd0);
        tag = "R11"; sw_wr = 1; sw_addr = 2'd0; sw_wdata = 32'h0012_3400; step();

        // secondary: sealed, never remapped
        tag = "R7"; cap2_valid = 1; cap2_word = 32'h33FF_FFFF; vec_len = 7; vec_iter = 3;
        vec_stride2 = 1; step(); rd(2'd1); rd(2'd2);
        tag = "R2"; sw_wr = 1; sw_addr = 2'd1; sw_wdata = 32'h0000_0010; step(); rd(2'd1);

        // software clears
        tag = "R8"; sw_wr = 1; sw_addr = 2'd2; sw_wdata = 32'h2; step();
        sw_wr = 1; sw_addr = 2'd2; sw_wdata = 32'h1; step();

        // capture wins over clear and over write
        tag = "R9"; capt(32'h0001_0000, 0, 0, 0); sw_wr = 1; sw_addr = 2'd2; sw_wdata = 0; step();
        cap2_valid = 1; cap2_word = 32'h00AB_CDEF; sw_wr = 1; sw_addr = 2'd2; sw_wdata = 0;
        step();
        capt(32'h0055_AA55, 0, 0, 0); sw_wr = 1; sw_addr = 2'd0; sw_wdata = 32'h0011_1111;
        step();
        cap2_valid = 1; cap2_word = 32'h0077_0077; sw_wr = 1; sw_addr = 2'd1;
        sw_wdata = 32'h0022_2222; step();
        tag = "R10"; sw_wr = 1; sw_addr = 2'd3; sw_wdata = '1; step(); rd(2'd2);

        // random traffic
        tag = "R3";
        for (int i = 0; i < 2000; i++) begin
            int l = $urandom_range(0, 7);
            cap_valid   = ($urandom_range(0, 3) == 0);
            cap_word    = $urandom;
            vec_len     = 3'(l);
            vec_iter    = 3'($urandom_range(0, l));
            vec_stride2 = $urandom_range(0, 1);
            cap2_valid  = ($urandom_range(0, 4) == 0);
            cap2_word   = $urandom;
            sw_wr       = ($urandom_range(0, 5) == 0);
            sw_addr     = 2'($urandom_range(0, 3));
            sw_wdata    = $urandom;
            step();
        end
        rst = 1; step();
        rst = 0; tag = "R10"; rd(2'd2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule